// File: doc/BRIEF.md
# Split-Phase Programmable Clock Divider

This block divides an input clock by any integer from 2 to 32. The low phase and the high phase of the output are set separately by two 4-bit fields. Each field holds the wanted number of input cycles minus one. A bypass bit passes the input clock straight to the output (divide by 1). A correction bit controls duty-cycle correction. When correction is on and the ratio is odd, the high phase is lengthened by half an input cycle and the low phase is shortened by the same amount, which moves the duty cycle toward 50%. After a reset or a sync pulse, the output can be held low for a programmed number of whole input cycles before the first period starts. This lets several channels be aligned to each other.

All state lives in the input clock domain. One negative-edge register delays the falling edge for the duty-cycle correction. The state machine has four states:
- `ST_BYPASS`: the counters are idle and the input clock is routed to the output.
- `ST_OFFSET`: the output is held low for the programmed number of delay cycles.
- `ST_LOW`: the output is low for the programmed low count.
- `ST_HIGH`: the output is high for the programmed high count.

The transitions are:
- **restart** (reset or sync, bypass clear): to `ST_OFFSET` if the delay is non-zero, else to `ST_LOW`.
- **offset done**: `ST_OFFSET` to `ST_LOW`.
- **low done**: `ST_LOW` to `ST_HIGH`.
- **period end**: `ST_HIGH` to `ST_LOW`. New fields are loaded here.
- **bypass on**: any state to `ST_BYPASS`.
- **bypass off**: `ST_BYPASS` to `ST_LOW`.

Two instances can be cascaded: the output of the first clocks the second.

Top module: `hl_clkdiv`

## Requirements
- R1: After `low_cnt_i` = M is loaded, every output period starts with M+1 input cycles at low level (before any correction).
- R2: After `high_cnt_i` = N is loaded, every output period ends with N+1 input cycles at high level (before any correction).
- R3: The output period is M+N+2 input cycles, so every ratio from 2 (M=N=0) to 32 (M=N=15) can be set.
- R4: While `bypass_i` is 1 (sampled on each rising input edge), `clk_o` follows `clk_i` from the next rising edge. When `bypass_i` returns to 0, the output restarts at the first low cycle with the current fields and no delay.
- R5: With `dcc_off_i` = 0 and M+N odd, the high level lasts (N+1)+0.5 input cycles: the output falls on the falling input edge inside the first cycle of the next low phase. With `dcc_off_i` = 1, or with M+N even, the output changes only on rising input edges.
- R6: At a rising edge where reset or sync is sampled, `delay_i` = D is captured. The output then stays low for D input cycles before the M+1 low cycles begin.
- R7: Changes to `low_cnt_i`, `high_cnt_i` and `dcc_off_i` take effect only at the end of a complete output period, or at a reset, sync or bypass exit.
- R8: While `rst_i` is 1 and `bypass_i` is 0, `clk_o` is low.
- R9: When two instances are cascaded, with the second clocked by the first's `clk_o`, the period of the second's output is the product of the two ratios. Either instance may be bypassed.
- R10: A sync pulse restarts the sequence immediately, even in mid-period, and cancels any pending half-cycle extension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous reset; restarts the sequence |
| sync_i | input | 1 | Synchronous restart pulse for channel alignment |
| bypass_i | input | 1 | 1 = route the input clock to the output (divide by 1) |
| dcc_off_i | input | 1 | 1 = disable half-cycle duty correction for odd ratios |
| low_cnt_i | input | CNT_W | Low phase length minus one (M) |
| high_cnt_i | input | CNT_W | High phase length minus one (N) |
| delay_i | input | OFS_W | Start delay in input cycles, applied after reset or sync |
| clk_o | output | 1 | Divided clock |

## Verification
The assertions check the following on every cycle:
- the phase counter never exceeds the loaded low or high field;
- each expiring phase moves to the correct next state;
- bypass is always entered;
- the held fields change only at a period boundary;
- a half-cycle extension is only ever armed right after a high phase and never survives a sync.

The actual output shape can only be shown by the bench scenarios: the half-cycle stretch, the start delay, the timing of a field change in mid-period, and the product ratio of two cascaded instances. The bench compares the output against a behavioural model on both input clock edges, and it measures the period of the cascaded pair directly.

// File: rtl/hl_clkdiv_pkg.sv
package hl_clkdiv_pkg;

    typedef enum logic [1:0] {
        ST_BYPASS = 2'd0,
        ST_OFFSET = 2'd1,
        ST_LOW    = 2'd2,
        ST_HIGH   = 2'd3
    } div_state_e;

    // An odd total ratio M+N+2 means M+N is odd.
    function automatic logic ratio_is_odd(input logic lsb_low, input logic lsb_high);
        return lsb_low ^ lsb_high;
    endfunction

endpackage

// File: rtl/hl_clkdiv_shadow.sv
module hl_clkdiv_shadow
    import hl_clkdiv_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] low_i,
    input  logic [CNT_W-1:0] high_i,
    input  logic             dcc_off_i,
    output logic [CNT_W-1:0] low_q,
    output logic [CNT_W-1:0] high_q,
    output logic             stretch_q
);

    // Held copies of the fields; reloaded only at the boundaries the FSM signals.
    always_ff @(posedge clk_i) begin
        if (load_i) begin
            low_q     <= low_i;
            high_q    <= high_i;
            stretch_q <= ~dcc_off_i & ratio_is_odd(low_i[0], high_i[0]);
        end
    end

endmodule

// File: rtl/hl_clkdiv_fsm.sv
module hl_clkdiv_fsm
    import hl_clkdiv_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int OFS_W = 4,
    parameter int CW    = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             sync_i,
    input  logic             bypass_i,
    input  logic [OFS_W-1:0] delay_i,
    input  logic [CNT_W-1:0] low_i,
    input  logic [CNT_W-1:0] low_q,
    input  logic [CNT_W-1:0] high_q,
    input  logic             stretch_q,
    output logic             load_o,
    output div_state_e       state_q,
    output logic [CW-1:0]    cnt_q,
    output logic             hi_q,
    output logic             tail_q
);

    div_state_e    state_d;
    logic [CW-1:0] cnt_d;
    logic          tail_d;
    logic          restart;
    logic          expired;

    assign restart = rst_i | sync_i;
    assign expired = (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q - CW'(1);
        load_o  = 1'b0;
        tail_d  = 1'b0;
        if (bypass_i) begin
            state_d = ST_BYPASS;
            cnt_d   = '0;
        end else if (restart) begin
            load_o = 1'b1;
            if (delay_i != '0) begin
                state_d = ST_OFFSET;
                cnt_d   = CW'(delay_i) - CW'(1);
            end else begin
                state_d = ST_LOW;
                cnt_d   = CW'(low_i);
            end
        end else begin
            unique case (state_q)
                ST_BYPASS: begin
                    load_o  = 1'b1;
                    state_d = ST_LOW;
                    cnt_d   = CW'(low_i);
                end
                ST_OFFSET: begin
                    if (expired) begin
                        state_d = ST_LOW;
                        cnt_d   = CW'(low_q);
                    end
                end
                ST_LOW: begin
                    if (expired) begin
                        state_d = ST_HIGH;
                        cnt_d   = CW'(high_q);
                    end
                end
                ST_HIGH: begin
                    if (expired) begin
                        load_o  = 1'b1;
                        state_d = ST_LOW;
                        cnt_d   = CW'(low_i);
                        tail_d  = stretch_q;
                    end
                end
                default: begin
                    state_d = ST_LOW;
                    cnt_d   = CW'(low_i);
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk_i) begin
        state_q <= state_d;
        cnt_q   <= cnt_d;
    end

    // Output register
    always_ff @(posedge clk_i) begin
        hi_q   <= (state_d == ST_HIGH);
        tail_q <= tail_d;
    end

endmodule

// File: rtl/hl_clkdiv_out.sv
module hl_clkdiv_out (
    input  logic clk_i,
    input  logic rst_i,
    input  logic byp_i,
    input  logic hi_q,
    input  logic tail_q,
    output logic clk_o
);

    logic hi_n;

    // Falling-edge copy of the high level; it keeps the output up for the
    // first half of the cycle after a high phase when a stretch is armed.
    always_ff @(negedge clk_i) begin
        if (rst_i) hi_n <= 1'b0;
        else       hi_n <= hi_q;
    end

    assign clk_o = byp_i ? clk_i : (hi_q | (tail_q & hi_n));

endmodule

// File: rtl/hl_clkdiv.sv
module hl_clkdiv
    import hl_clkdiv_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int OFS_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             sync_i,
    input  logic             bypass_i,
    input  logic             dcc_off_i,
    input  logic [CNT_W-1:0] low_cnt_i,
    input  logic [CNT_W-1:0] high_cnt_i,
    input  logic [OFS_W-1:0] delay_i,
    output logic             clk_o
);

    localparam int CW = (CNT_W > OFS_W) ? CNT_W : OFS_W;

    logic             load;
    logic [CNT_W-1:0] low_q;
    logic [CNT_W-1:0] high_q;
    logic             stretch_q;
    div_state_e       state_q;
    logic [CW-1:0]    cnt_q;
    logic             hi_q;
    logic             tail_q;

    hl_clkdiv_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk_i     (clk_i),
        .load_i    (load),
        .low_i     (low_cnt_i),
        .high_i    (high_cnt_i),
        .dcc_off_i (dcc_off_i),
        .low_q     (low_q),
        .high_q    (high_q),
        .stretch_q (stretch_q)
    );

    hl_clkdiv_fsm #(.CNT_W(CNT_W), .OFS_W(OFS_W), .CW(CW)) u_fsm (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .sync_i    (sync_i),
        .bypass_i  (bypass_i),
        .delay_i   (delay_i),
        .low_i     (low_cnt_i),
        .low_q     (low_q),
        .high_q    (high_q),
        .stretch_q (stretch_q),
        .load_o    (load),
        .state_q   (state_q),
        .cnt_q     (cnt_q),
        .hi_q      (hi_q),
        .tail_q    (tail_q)
    );

    hl_clkdiv_out u_out (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .byp_i  (state_q == ST_BYPASS),
        .hi_q   (hi_q),
        .tail_q (tail_q),
        .clk_o  (clk_o)
    );

endmodule

// File: rtl/hl_clkdiv_chk.sv
module hl_clkdiv_chk
    import hl_clkdiv_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int OFS_W = 4
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             sync_i,
    input logic             bypass_i,
    input div_state_e       state_q,
    input logic [((CNT_W > OFS_W) ? CNT_W : OFS_W)-1:0] cnt_q,
    input logic             hi_q,
    input logic             tail_q,
    input logic [CNT_W-1:0] low_q,
    input logic [CNT_W-1:0] high_q
);

    localparam int CW = (CNT_W > OFS_W) ? CNT_W : OFS_W;

    logic quiet;
    assign quiet = !rst_i && !sync_i && !bypass_i;

    p_low_bound_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_LOW) |-> (cnt_q <= CW'(low_q)));

    p_high_bound_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_HIGH) |-> (cnt_q <= CW'(high_q)));

    p_low_to_high_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (quiet && state_q == ST_LOW && cnt_q == '0) |=> (state_q == ST_HIGH));

    p_high_to_low_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (quiet && state_q == ST_HIGH && cnt_q == '0) |=> (state_q == ST_LOW));

    p_bypass_enter_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        bypass_i |=> (state_q == ST_BYPASS));

    p_tail_after_high_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        tail_q |-> ($past(state_q) == ST_HIGH && state_q == ST_LOW));

    p_offset_low_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_OFFSET) |-> !hi_q);

    p_fields_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (quiet && state_q != ST_BYPASS && !(state_q == ST_HIGH && cnt_q == '0))
        |=> ($stable(low_q) && $stable(high_q)));

    p_sync_clears_tail_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        sync_i |=> !tail_q);

endmodule

bind hl_clkdiv hl_clkdiv_chk #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .sync_i   (sync_i),
    .bypass_i (bypass_i),
    .state_q  (state_q),
    .cnt_q    (cnt_q),
    .hi_q     (hi_q),
    .tail_q   (tail_q),
    .low_q    (low_q),
    .high_q   (high_q)
);

// File: tb/hl_clkdiv_test.sv
`timescale 1ns/1ps
module hl_clkdiv_test;

    logic       clk = 1'b0;
    logic       rst, sync, bypass, dcc_off;
    logic [3:0] low_cnt, high_cnt, delay;
    logic       clk_o;

    int    tests = 0;
    int    fails = 0;
    bit    chk_en = 0;
    bit    done = 0;
    string cur_req = "R8";

    always #10 clk = ~clk;

    hl_clkdiv uut (
        .clk_i(clk), .rst_i(rst), .sync_i(sync), .bypass_i(bypass),
        .dcc_off_i(dcc_off), .low_cnt_i(low_cnt), .high_cnt_i(high_cnt),
        .delay_i(delay), .clk_o(clk_o)
    );

    // Cascade pair for R9
    logic       ra, ba, rb, bb;
    logic [3:0] ma, na, mb, nb;
    logic       ca_o, cb_o;

    hl_clkdiv uchain_a (
        .clk_i(clk), .rst_i(ra), .sync_i(1'b0), .bypass_i(ba), .dcc_off_i(1'b0),
        .low_cnt_i(ma), .high_cnt_i(na), .delay_i(4'd0), .clk_o(ca_o)
    );
    hl_clkdiv uchain_b (
        .clk_i(ca_o), .rst_i(rb), .sync_i(1'b0), .bypass_i(bb), .dcc_off_i(1'b0),
        .low_cnt_i(mb), .high_cnt_i(nb), .delay_i(4'd0), .clk_o(cb_o)
    );

    task automatic check(input logic act, input logic exp);
        if (chk_en) begin
            tests++;
            if (act !== exp) begin
                fails++;
                $display("FAIL %s at %0t: actual=%b expected=%b", cur_req, $time, act, exp);
            end
        end
    endtask

    // Behavioural reference: one expected level per half input cycle.
    int cm, cn, ofs_left, hp;
    bit cd, tail, wrap, mbyp;
    logic ea, eb;

    task automatic load_cur();
        cm = int'(low_cnt);
        cn = int'(high_cnt);
        cd = !dcc_off;
    endtask

    always @(posedge clk) begin
        if (bypass) begin
            mbyp = 1; ea = 1'b1; eb = 1'b0;
        end else begin
            if (rst || sync) begin
                load_cur(); ofs_left = int'(delay); hp = 0; tail = 0; wrap = 0;
            end else if (mbyp) begin
                load_cur(); ofs_left = 0; hp = 0; tail = 0; wrap = 0;
            end else if (wrap) begin
                tail = (((cm + cn) % 2) == 1) && cd;
                load_cur(); hp = 0; wrap = 0;
            end
            mbyp = 0;
            if (ofs_left > 0) begin
                ea = 1'b0; eb = 1'b0; ofs_left--;
            end else begin
                if (hp < cm + 1) begin
                    ea = (hp == 0) && tail; eb = 1'b0;
                end else begin
                    ea = 1'b1; eb = 1'b1;
                end
                hp++;
                if (hp == cm + cn + 2) wrap = 1;
            end
        end
        #5 check(clk_o, ea);
    end

    always @(negedge clk) begin
        #5 check(clk_o, eb);
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic drive(input logic [3:0] m, input logic [3:0] n, input logic doff);
        @(negedge clk); #1;
        low_cnt = m; high_cnt = n; dcc_off = doff;
    endtask

    task automatic pulse_sync(input logic [3:0] d);
        @(negedge clk); #1;
        delay = d; sync = 1'b1;
        @(negedge clk); #1;
        sync = 1'b0;
    endtask

    task automatic measure_chain(input int expect_cyc, input string tag);
        longint t0, t1;
        ra = 1'b1; rb = 1'b1;
        cycles(4);
        @(negedge clk); #1; ra = 1'b0;
        cycles(150);
        @(negedge clk); #1; rb = 1'b0;
        cycles(200);
        @(posedge cb_o); t0 = longint'($time);
        @(posedge cb_o); t1 = longint'($time);
        tests++;
        if ((t1 - t0) != longint'(expect_cyc) * 20) begin
            fails++;
            $display("FAIL %s cascade period: actual=%0d expected=%0d", tag,
                     (t1 - t0) / 20, expect_cyc);
        end
    endtask

    initial begin
        rst = 1'b1; sync = 1'b0; bypass = 1'b0; dcc_off = 1'b1;
        low_cnt = 4'd0; high_cnt = 4'd0; delay = 4'd0;
        ra = 1'b1; rb = 1'b1; ba = 1'b0; bb = 1'b0;
        ma = 4'd0; na = 4'd0; mb = 4'd0; nb = 4'd0;
        cycles(2);
        @(negedge clk); chk_en = 1;
        // R8: output low during reset
        cycles(6);
        // R1 R2 R3: low 3, high 2, ratio 5 without correction
        cur_req = "R1 R2 R3";
        drive(4'd2, 4'd1, 1'b1);
        @(negedge clk); #1; rst = 1'b0;
        cycles(40);
        // R7: fields changed mid-period apply at the period end (odd, corrected)
        cur_req = "R7";
        cycles(2);
        drive(4'd1, 4'd2, 1'b0);
        cycles(20);
        // R5: odd ratio with correction, then with correction disabled
        cur_req = "R5";
        cycles(30);
        drive(4'd1, 4'd2, 1'b1);
        cycles(30);
        drive(4'd0, 4'd1, 1'b0);
        cycles(24);
        // R3: ratio 2 (even, correction requested but unused) and ratio 32
        cur_req = "R3";
        drive(4'd0, 4'd0, 1'b0);
        cycles(20);
        drive(4'd15, 4'd15, 1'b1);
        cycles(80);
        drive(4'd3, 4'd6, 1'b0);
        cycles(40);
        // R6: start delay after sync
        cur_req = "R6";
        drive(4'd2, 4'd2, 1'b1);
        pulse_sync(4'd5);
        cycles(30);
        drive(4'd3, 4'd2, 1'b0);
        pulse_sync(4'd15);
        cycles(50);
        // R10: syncs at assorted points, including during a pending stretch
        cur_req = "R10";
        drive(4'd1, 4'd0, 1'b0);
        for (int k = 0; k < 8; k++) begin
            pulse_sync(4'd0);
            cycles(k % 5);
        end
        cycles(20);
        // R4: bypass on and off
        cur_req = "R4";
        @(negedge clk); #1; bypass = 1'b1;
        cycles(12);
        drive(4'd2, 4'd3, 1'b1);
        @(negedge clk); #1; bypass = 1'b0;
        cycles(30);
        // R8: reset again with bypass clear
        cur_req = "R8";
        @(negedge clk); #1; rst = 1'b1; delay = 4'd3;
        cycles(8);
        @(negedge clk); #1; rst = 1'b0;
        cur_req = "R6";
        cycles(30);
        // R9: cascade products
        ma = 4'd0; na = 4'd1; mb = 4'd1; nb = 4'd2; ba = 1'b0; bb = 1'b0;
        measure_chain(15, "R9");
        ba = 1'b1; mb = 4'd1; nb = 4'd1;
        measure_chain(4, "R9");
        ba = 1'b0; ma = 4'd3; na = 4'd2; bb = 1'b1;
        measure_chain(7, "R9");
        chk_en = 0;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule